// File: doc/BRIEF.md
# Coherent Two-Byte Conversion Result Register

This block sits between a converter core and a byte-wide processor bus. It keeps the most recent 10-bit conversion result and presents it as two read-only bytes, a high byte and a low byte. A read-order interlock keeps a 10-bit read coherent. Reading the low byte freezes the stored result. The freeze lasts until the high byte is read, so a conversion that finishes between the two reads cannot mix bytes from two samples.

A justify input sets how the result is split across the two bytes, and the layout is worked out when the read happens. With left justification, software that needs only eight bits reads the high byte alone. That read never leaves the interlock engaged. A conversion that arrives while the interlock holds is dropped, and a one-cycle lost-result pulse reports the drop.

Top module: `rlk_result_pair`

## Requirements
- R1: A synchronous active-high reset clears the stored result, the interlock, the read data output and the lost-result pulse to zero.
- R2: A low-byte read (`rd_en`=1, `rd_sel`=0) engages the interlock. While it is engaged, no conversion changes the stored result.
- R3: A conversion strobe that is not accepted is discarded, not queued. The clock edge that discards it raises `lost_pulse` for exactly one cycle. `lost_pulse` is 0 in every other cycle.
- R4: A high-byte read (`rd_en`=1, `rd_sel`=1) releases the interlock. A high-byte read while unlocked has no side effect, so a conversion that follows it is accepted.
- R5: With `left_just`=0, the high byte is {6'b0, result[9:8]} and the low byte is result[7:0].
- R6: With `left_just`=1, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R7: When the interlock is released, a strobe on `cv_valid` stores `cv_data` at the next clock edge. The justify setting used is the one present at the cycle of the read, whichever setting was present when the result was stored.
- R8: A low-byte read together with a conversion strobe in the same cycle returns the previously stored value and engages the interlock. The new conversion is discarded and reported on `lost_pulse`.
- R9: `rd_data` is registered. The edge that ends a read cycle loads it, so it is visible in the following cycle. It holds its value through cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cv_valid | input | 1 | One-cycle strobe: a conversion result is ready |
| cv_data | input | 10 | Conversion result that goes with `cv_valid` |
| rd_en | input | 1 | Bus read strobe |
| rd_sel | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| left_just | input | 1 | 1 = left-justified layout, 0 = right-justified |
| rd_data | output | 8 | Registered read data |
| lost_pulse | output | 1 | One-cycle pulse for a discarded conversion |

## Verification
The assertions assume that `rd_sel` and `left_just` are stable in any cycle where `rd_en` is high. They also assume that `cv_valid` is a single-cycle strobe whose data is valid in that same cycle. The stimulus drives every input once per cycle, at the falling edge. It changes the select and justify lines only together with the read strobe that uses them. Conversions are mixed with low reads, high reads and idle cycles, and the mix includes the same-cycle collisions in both lock states.

// File: rtl/rlk_pkg.sv
package rlk_pkg;
  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/rlk_capture.sv
module rlk_capture #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cv_valid,
  input  logic [RES_W-1:0] cv_data,
  input  logic             lo_rd,
  input  logic             hi_rd,
  output logic [RES_W-1:0] stored,
  output logic             locked,
  output logic             lost_pulse
);
  logic accept;

  // A new result is taken only when no lock exists and none is starting now.
  always_comb accept = cv_valid && !locked && !lo_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      stored     <= '0;
      locked     <= 1'b0;
      lost_pulse <= 1'b0;
    end else begin
      if (accept) stored <= cv_data;
      if (lo_rd)      locked <= 1'b1;
      else if (hi_rd) locked <= 1'b0;
      lost_pulse <= cv_valid && !accept;
    end
  end

  // R2
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> stored == $past(stored));
  // R3
  lost_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (cv_valid && locked) |=> lost_pulse);
  // R3
  no_spurious_lost_chk: assert property (@(posedge clk) disable iff (rst)
    !cv_valid |=> !lost_pulse);
  // R7
  load_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    (cv_valid && !locked && !lo_rd) |=> stored == $past(cv_data));
  // R4
  hi_release_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_rd && !lo_rd) |=> !locked);
endmodule

// File: rtl/rlk_layout.sv
module rlk_layout #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic              left_just,
  output logic [BYTE_W-1:0] hi_byte,
  output logic [BYTE_W-1:0] lo_byte
);
  localparam int SPILL = RES_W - BYTE_W;
  localparam int PAD   = BYTE_W - SPILL;

  logic [BYTE_W-1:0] r_hi, r_lo, l_hi, l_lo;

  assign r_lo = res[BYTE_W-1:0];
  assign l_hi = res[RES_W-1 -: BYTE_W];

  generate
    if (PAD > 0) begin : g_pad
      assign r_hi = {{PAD{1'b0}}, res[RES_W-1:BYTE_W]};
      assign l_lo = {res[SPILL-1:0], {PAD{1'b0}}};
    end else begin : g_nopad
      assign r_hi = res[RES_W-1:BYTE_W];
      assign l_lo = res[SPILL-1:0];
    end
  endgenerate

  always_comb begin
    hi_byte = left_just ? l_hi : r_hi;
    lo_byte = left_just ? l_lo : r_lo;
  end
endmodule

// File: rtl/rlk_readport.sv
module rlk_readport
  import rlk_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  byte_sel_e         sel,
  input  logic [BYTE_W-1:0] hi_byte,
  input  logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= (sel == SEL_HIGH) ? hi_byte : lo_byte;
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/rlk_result_pair.sv
module rlk_result_pair
  import rlk_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cv_valid,
  input  logic [RES_W-1:0]  cv_data,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              left_just,
  output logic [BYTE_W-1:0] rd_data,
  output logic              lost_pulse
);
  localparam int SPILL = RES_W - BYTE_W;
  localparam int PAD   = BYTE_W - SPILL;

  byte_sel_e         sel;
  logic              lo_rd, hi_rd, locked;
  logic [RES_W-1:0]  stored;
  logic [BYTE_W-1:0] hi_byte, lo_byte;

  assign sel   = byte_sel_e'(rd_sel);
  assign lo_rd = rd_en && (sel == SEL_LOW);
  assign hi_rd = rd_en && (sel == SEL_HIGH);

  rlk_capture #(.RES_W(RES_W)) i_capture (
    .clk(clk), .rst(rst), .cv_valid(cv_valid), .cv_data(cv_data),
    .lo_rd(lo_rd), .hi_rd(hi_rd), .stored(stored), .locked(locked),
    .lost_pulse(lost_pulse)
  );

  rlk_layout #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_layout (
    .res(stored), .left_just(left_just), .hi_byte(hi_byte), .lo_byte(lo_byte)
  );

  rlk_readport #(.BYTE_W(BYTE_W)) i_readport (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel),
    .hi_byte(hi_byte), .lo_byte(lo_byte), .rd_data(rd_data)
  );

  // R5
  right_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_rd && !left_just) |=> rd_data[BYTE_W-1:SPILL] == '0);
  // R6
  left_lo_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_rd && left_just) |=> rd_data[PAD-1:0] == '0);
  // R8
  collide_lost_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_rd && cv_valid) |=> lost_pulse);
endmodule

// File: tb/test_rlk_result_pair.sv
`timescale 1ns/1ps
module test_rlk_result_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cv_valid = 1'b0;
  logic [9:0] cv_data = '0;
  logic       rd_en = 1'b0;
  logic       rd_sel = 1'b0;
  logic       left_just = 1'b0;
  logic [7:0] rd_data;
  logic       lost_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rlk_result_pair i_rlk_result_pair (
    .clk(clk), .rst(rst), .cv_valid(cv_valid), .cv_data(cv_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .left_just(left_just),
    .rd_data(rd_data), .lost_pulse(lost_pulse)
  );

  // {valid, data, rd_en, rd_sel, left, expected rd_data, expected lost}
  localparam int NV = 18;
  localparam logic [22:0] VTAB [NV] = '{
    {1'b1, 10'h2B5, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 8'hB5, 1'b0},
    {1'b1, 10'h155, 1'b0, 1'b0, 1'b0, 8'hB5, 1'b1},
    {1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 8'h02, 1'b0},
    {1'b1, 10'h155, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0},
    {1'b0, 10'h000, 1'b1, 1'b1, 1'b1, 8'h55, 1'b0},
    {1'b1, 10'h3FF, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0},
    {1'b0, 10'h000, 1'b1, 1'b0, 1'b1, 8'hC0, 1'b0},
    {1'b1, 10'h001, 1'b1, 1'b0, 1'b1, 8'hC0, 1'b1},
    {1'b0, 10'h000, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0},
    {1'b1, 10'h001, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b1},
    {1'b1, 10'h0AA, 1'b1, 1'b1, 1'b0, 8'h03, 1'b1},
    {1'b1, 10'h0AA, 1'b0, 1'b0, 1'b0, 8'h03, 1'b0},
    {1'b0, 10'h000, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    {1'b1, 10'h201, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 8'h01, 1'b0},
    {1'b0, 10'h000, 1'b1, 1'b1, 1'b1, 8'h80, 1'b0},
    {1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 8'h80, 1'b0}
  };
  localparam string VTAG [NV] = '{
    "R7 R9", "R2 R5", "R2 R3", "R4 R5", "R4 R7", "R6 R4", "R7", "R6 R2",
    "R2 R3", "R6 R4", "R8", "R3 R4", "R4 R7", "R4 R5", "R4 R7", "R5 R2",
    "R6 R7", "R9"
  };

  task automatic chk8(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic chk1(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s lost_pulse actual=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [9:0] d, input logic r,
                       input logic s, input logic l);
    cv_valid = v; cv_data = d; rd_en = r; rd_sel = s; left_just = l;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk8("R1", rd_data, 8'h00);
    chk1("R1", lost_pulse, 1'b0);
    drive(1'b0, 10'h0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk8("R1", rd_data, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VTAB[i][22], VTAB[i][21:12], VTAB[i][11], VTAB[i][10], VTAB[i][9]);
      @(negedge clk);
      chk8(VTAG[i], rd_data, VTAB[i][8:1]);
      chk1(VTAG[i], lost_pulse, VTAB[i][0]);
    end

    // R3: lost pulse lasts a single cycle
    drive(1'b0, 10'h0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b1, 10'h0F0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk1("R3", lost_pulse, 1'b1);
    drive(1'b0, 10'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk1("R3", lost_pulse, 1'b0);

    // R1: reset while locked clears lock and read data
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk8("R1", rd_data, 8'h00);
    chk1("R1", lost_pulse, 1'b0);
    drive(1'b1, 10'h123, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk1("R1", lost_pulse, 1'b0);
    drive(1'b0, 10'h0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk8("R1", rd_data, 8'h23);
    drive(1'b0, 10'h0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk8("R6", rd_data, 8'h48);
    drive(1'b0, 10'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule